// File: doc/BRIEF.md
# Dual-Channel Split FIFO Controller

This block holds one 16-level by 32-bit data store and divides it between two disk-interface channels. A split code decides how many levels each channel owns, and a per-channel threshold code decides how full (or how empty) that channel's partition must be before it asks the DMA engine for service. Each channel has its own push port, show-ahead pop port, occupancy count, DMA request, DMA-capable flag and sticky error flag.

Two drain mechanisms let a device-to-memory channel send out data that sits below its threshold. One fires on the rising edge of that channel's interrupt. The other fires each time a programmed number of bytes per sector has been pushed. A new split and threshold setting is held pending until both partitions are empty and idle, so data is never re-addressed while it is in flight. After reset the block picks its own setting from the two channel-enable inputs.

Top module: `split_fifo_ctrl`

## Requirements
- R1: Each channel's partition returns its words in push order. `pop_data_o` shows the oldest word while the partition is not empty, and a pop removes that word.
- R2: The split code gives channel 0 / channel 1 these level counts: 00 gives 16/0, 01 gives 8/8, 10 gives 8/8 and 11 gives 0/16. `dma_cap_o[c]` is 1 exactly when channel c owns at least one level.
- R3: A channel that owns zero levels never raises `dma_req_o` in either direction. A push to it is not stored and sets its error flag.
- R4: The threshold code of channel c sits in `cfg_thr_i[2c+1:2c]`. Code 00 means the whole partition depth, 01 means 3/4 of it, 10 means 1/2 and 11 means 1/4.
- R5: With `dir_i[c]`=1 (device to memory), the request is high while the occupancy is at or above the threshold. With `dir_i[c]`=0 (memory to device), it is high while the free space is at or above the threshold.
- R6: When `rd_flush_en_i[c]`=1 and `dir_i[c]`=1, a rising edge of `irq_i[c]` keeps the request high until the partition is empty. When the enable is 0, the edge has no effect.
- R7: While `eos_flush_en_i[c]`=1, the block counts 4 bytes per accepted push. When the count reaches `sect_bytes_i[12c+11:12c]`, the count restarts and the partition drains as in R6. While the enable is 0, the count is held at zero.
- R8: The setting is chosen on the first clock after reset. `chan_en_i`=01 selects split 00 with threshold 3/4 for channel 0. `chan_en_i`=10 selects split 11 with threshold 3/4 for channel 1. Any other value selects split 01 with threshold 1/2 for both channels.
- R9: A pulse on `cfg_load_i` captures a pending setting. It takes effect on the first later clock at which both partitions are empty and see no push or pop. Until then the old setting stays in force.
- R10: A push to a full partition or a pop from an empty one is ignored and sets `err_o[c]`. The flag stays set until reset.
- R11: `level_o[5c+4:5c]` holds channel c's occupancy. An accepted push or pop changes it in the cycle after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 2 | Channel enables used for the setting chosen after reset |
| cfg_load_i | input | 1 | Captures a new pending setting |
| cfg_split_i | input | 2 | Split code |
| cfg_thr_i | input | 4 | Threshold codes, channel 0 in [1:0], channel 1 in [3:2] |
| dir_i | input | 2 | Per-channel direction, 1 = device to memory |
| push_i | input | 2 | Per-channel push strobe |
| push_data_i | input | 64 | Push data, channel c in [32c+31:32c] |
| pop_i | input | 2 | Per-channel pop strobe |
| pop_data_o | output | 64 | Oldest word of each partition |
| level_o | output | 10 | Occupancy, channel c in [5c+4:5c] |
| dma_req_o | output | 2 | Per-channel DMA request |
| dma_cap_o | output | 2 | Per-channel DMA-capable flag |
| irq_i | input | 2 | Per-channel interrupt |
| rd_flush_en_i | input | 2 | Enable for the drain on interrupt |
| eos_flush_en_i | input | 2 | Enable for the drain at sector end |
| sect_bytes_i | input | 24 | Bytes per sector, channel c in [12c+11:12c] |
| err_o | output | 2 | Sticky overflow or underflow flag |

## Verification
Occupancy, request, pop data and error flags all come from registers or from logic fed by registers. Each of them therefore changes just after the edge that accepts a push, pop or interrupt edge. The bench drives its inputs on a falling edge and reads the results on the next falling edge. A new setting needs two edges, one to capture it and one to apply it once the block is idle, so the bench waits at least two falling edges after the last pop before it checks `dma_cap_o`. The setting chosen after reset appears after the first edge with reset released, and the bench waits for that edge too.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef struct packed {
    logic [1:0] split;
    logic [1:0] thr1;
    logic [1:0] thr0;
  } sfc_cfg_t;

  localparam logic [1:0] SPLIT_ALL0 = 2'b00;
  localparam logic [1:0] SPLIT_EVEN = 2'b01;
  localparam logic [1:0] SPLIT_ALL1 = 2'b11;
  localparam logic [1:0] THR_3Q     = 2'b01;
  localparam logic [1:0] THR_HALF   = 2'b10;

  function automatic sfc_cfg_t reset_cfg(input logic [1:0] chan_en);
    sfc_cfg_t c;
    case (chan_en)
      2'b01:   c = '{split: SPLIT_ALL0, thr1: THR_3Q,   thr0: THR_3Q};
      2'b10:   c = '{split: SPLIT_ALL1, thr1: THR_3Q,   thr0: THR_3Q};
      default: c = '{split: SPLIT_EVEN, thr1: THR_HALF, thr0: THR_HALF};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sfc_cfg.sv
module sfc_cfg
  import sfc_pkg::*;
#(
  parameter int LEVELS = 16,
  localparam int CW = $clog2(LEVELS) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    chan_en_i,
  input  logic          load_i,
  input  sfc_cfg_t      new_cfg_i,
  input  logic [1:0]    busy_i,
  output logic          apply_o,
  output logic [CW-1:0] depth0_o,
  output logic [CW-1:0] depth1_o,
  output logic [1:0]    thr0_o,
  output logic [1:0]    thr1_o
);
  sfc_cfg_t cfg_q, pend_q, active, dflt;
  logic     init_q, pend_v_q;

  assign dflt    = reset_cfg(chan_en_i);
  assign active  = init_q ? dflt : cfg_q;
  assign apply_o = !init_q && pend_v_q && (busy_i == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q   <= 1'b1;
      pend_v_q <= 1'b0;
      pend_q   <= '0;
      cfg_q    <= '0;
    end else begin
      init_q <= 1'b0;
      if (init_q)       cfg_q <= dflt;
      else if (apply_o) cfg_q <= pend_q;
      if (load_i) begin
        pend_q   <= new_cfg_i;
        pend_v_q <= 1'b1;
      end else if (apply_o) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (active.split)
      2'b00:   depth0_o = CW'(LEVELS);
      2'b11:   depth0_o = '0;
      default: depth0_o = CW'(LEVELS / 2);
    endcase
    depth1_o = CW'(LEVELS) - depth0_o;
  end

  assign thr0_o = active.thr0;
  assign thr1_o = active.thr1;
endmodule

// File: rtl/sfc_store.sv
module sfc_store #(
  parameter int LEVELS = 16,
  parameter int DW = 32,
  localparam int AW = $clog2(LEVELS)
) (
  input  logic                clk_i,
  input  logic [1:0]          we_i,
  input  logic [1:0][AW-1:0]  waddr_i,
  input  logic [1:0][DW-1:0]  wdata_i,
  input  logic [1:0][AW-1:0]  raddr_i,
  output logic [1:0][DW-1:0]  rdata_o
);
  logic [DW-1:0] mem_q [LEVELS];

  for (genvar e = 0; e < LEVELS; e++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (we_i[0] && waddr_i[0] == AW'(e))      mem_q[e] <= wdata_i[0];
      else if (we_i[1] && waddr_i[1] == AW'(e)) mem_q[e] <= wdata_i[1];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end
endmodule

// File: rtl/sfc_part.sv
module sfc_part #(
  parameter int LEVELS = 16,
  parameter int DW = 32,
  parameter int SECT_W = 12,
  localparam int AW = $clog2(LEVELS),
  localparam int CW = AW + 1,
  localparam int BPL = DW / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     depth_i,
  input  logic [CW-1:0]     base_i,
  input  logic [1:0]        thr_code_i,
  input  logic              restart_i,
  input  logic              dir_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              irq_i,
  input  logic              rd_flush_en_i,
  input  logic              eos_flush_en_i,
  input  logic [SECT_W-1:0] sect_bytes_i,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [CW-1:0]     level_o,
  output logic              req_o,
  output logic              cap_o,
  output logic              err_o,
  output logic              busy_o
);
  logic [AW-1:0]     wr_off_q, rd_off_q;
  logic [CW-1:0]     occ_q, occ_nxt, thr_lvl, wsum, rsum;
  logic [SECT_W-1:0] sect_q;
  logic [SECT_W:0]   sect_nxt;
  logic              push_ok, pop_ok, irq_q, drain_q, drain_set, sect_hit;

  assign push_ok = push_i && (occ_q < depth_i);
  assign pop_ok  = pop_i && (occ_q != '0);
  assign wr_en_o = push_ok;
  assign wsum    = base_i + CW'(wr_off_q);
  assign rsum    = base_i + CW'(rd_off_q);
  assign wr_addr_o = wsum[AW-1:0];
  assign rd_addr_o = rsum[AW-1:0];
  assign level_o = occ_q;
  assign cap_o   = depth_i != '0;
  assign busy_o  = (occ_q != '0) || push_i || pop_i;

  always_comb begin
    occ_nxt = occ_q;
    if (push_ok && !pop_ok)      occ_nxt = occ_q + 1'b1;
    else if (pop_ok && !push_ok) occ_nxt = occ_q - 1'b1;
  end

  always_comb begin
    case (thr_code_i)
      2'b00:   thr_lvl = depth_i;
      2'b01:   thr_lvl = depth_i - (depth_i >> 2);
      2'b10:   thr_lvl = depth_i >> 1;
      default: thr_lvl = depth_i >> 2;
    endcase
  end

  // sector byte count; a hit restarts the count
  assign sect_nxt  = {1'b0, sect_q} + (SECT_W+1)'(BPL);
  assign sect_hit  = eos_flush_en_i && push_ok && (sect_bytes_i != '0) &&
                     (sect_nxt >= {1'b0, sect_bytes_i});
  assign drain_set = (irq_i && !irq_q && rd_flush_en_i) || sect_hit;

  always_comb begin
    if (!cap_o)     req_o = 1'b0;
    else if (dir_i) req_o = (occ_q >= thr_lvl) || (drain_q && occ_q != '0);
    else            req_o = (depth_i - occ_q) >= thr_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_off_q <= '0;
      rd_off_q <= '0;
      occ_q    <= '0;
      err_o    <= 1'b0;
      irq_q    <= 1'b0;
      drain_q  <= 1'b0;
      sect_q   <= '0;
    end else begin
      irq_q <= irq_i;
      if ((push_i && !push_ok) || (pop_i && !pop_ok)) err_o <= 1'b1;
      if (restart_i) begin
        wr_off_q <= '0;
        rd_off_q <= '0;
        drain_q  <= 1'b0;
      end else begin
        if (push_ok) wr_off_q <= (CW'(wr_off_q) == depth_i - 1'b1) ? '0 : wr_off_q + 1'b1;
        if (pop_ok)  rd_off_q <= (CW'(rd_off_q) == depth_i - 1'b1) ? '0 : rd_off_q + 1'b1;
        drain_q <= drain_set || (drain_q && occ_nxt != '0);
      end
      occ_q <= occ_nxt;
      if (!eos_flush_en_i) sect_q <= '0;
      else if (sect_hit)   sect_q <= '0;
      else if (push_ok)    sect_q <= sect_nxt[SECT_W-1:0];
    end
  end
endmodule

// File: rtl/split_fifo_ctrl.sv
module split_fifo_ctrl
  import sfc_pkg::*;
#(
  parameter int LEVELS = 16,
  parameter int DW = 32,
  parameter int SECT_W = 12,
  localparam int AW = $clog2(LEVELS),
  localparam int CW = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        chan_en_i,
  input  logic              cfg_load_i,
  input  logic [1:0]        cfg_split_i,
  input  logic [3:0]        cfg_thr_i,
  input  logic [1:0]        dir_i,
  input  logic [1:0]        push_i,
  input  logic [2*DW-1:0]   push_data_i,
  input  logic [1:0]        pop_i,
  output logic [2*DW-1:0]   pop_data_o,
  output logic [2*CW-1:0]   level_o,
  output logic [1:0]        dma_req_o,
  output logic [1:0]        dma_cap_o,
  input  logic [1:0]        irq_i,
  input  logic [1:0]        rd_flush_en_i,
  input  logic [1:0]        eos_flush_en_i,
  input  logic [2*SECT_W-1:0] sect_bytes_i,
  output logic [1:0]        err_o
);
  sfc_cfg_t              new_cfg;
  logic                  apply;
  logic [1:0]            busy, we;
  logic [1:0][CW-1:0]    depth, base;
  logic [1:0][1:0]       thr;
  logic [1:0][AW-1:0]    waddr, raddr;
  logic [1:0][DW-1:0]    wdata, rdata;

  assign new_cfg = '{split: cfg_split_i, thr1: cfg_thr_i[3:2], thr0: cfg_thr_i[1:0]};
  assign base[0] = '0;
  assign base[1] = depth[0];

  sfc_cfg #(.LEVELS(LEVELS)) i_cfg (
    .clk_i, .rst_ni, .chan_en_i,
    .load_i(cfg_load_i), .new_cfg_i(new_cfg), .busy_i(busy),
    .apply_o(apply), .depth0_o(depth[0]), .depth1_o(depth[1]),
    .thr0_o(thr[0]), .thr1_o(thr[1])
  );

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign wdata[c] = push_data_i[c*DW +: DW];
    assign pop_data_o[c*DW +: DW] = rdata[c];
    sfc_part #(.LEVELS(LEVELS), .DW(DW), .SECT_W(SECT_W)) i_part (
      .clk_i, .rst_ni,
      .depth_i(depth[c]), .base_i(base[c]), .thr_code_i(thr[c]), .restart_i(apply),
      .dir_i(dir_i[c]), .push_i(push_i[c]), .pop_i(pop_i[c]), .irq_i(irq_i[c]),
      .rd_flush_en_i(rd_flush_en_i[c]), .eos_flush_en_i(eos_flush_en_i[c]),
      .sect_bytes_i(sect_bytes_i[c*SECT_W +: SECT_W]),
      .wr_en_o(we[c]), .wr_addr_o(waddr[c]), .rd_addr_o(raddr[c]),
      .level_o(level_o[c*CW +: CW]), .req_o(dma_req_o[c]), .cap_o(dma_cap_o[c]),
      .err_o(err_o[c]), .busy_o(busy[c])
    );
  end

  sfc_store #(.LEVELS(LEVELS), .DW(DW)) i_store (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
  parameter int LEVELS = 16,
  localparam int CW = $clog2(LEVELS) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    pop_i,
  input logic [2*CW-1:0] level_o,
  input logic [1:0]    dma_req_o,
  input logic [1:0]    dma_cap_o,
  input logic [1:0]    err_o
);
  logic [CW-1:0] lv0, lv1;
  assign lv0 = level_o[CW-1:0];
  assign lv1 = level_o[2*CW-1:CW];

  p_no_req_unalloc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o & ~dma_cap_o) == 2'b00);

  p_share_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, lv0} + {1'b0, lv1}) <= (CW+1)'(LEVELS));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[0] |=> err_o[0]);

  p_err_sticky1_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[1] |=> err_o[1]);

  p_underflow0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i[0] && lv0 == '0) |=> err_o[0]);

  p_underflow1_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i[1] && lv1 == '0) |=> err_o[1]);

  p_level_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv0 == $past(lv0)) || (lv0 == $past(lv0) + 1'b1) || (lv0 == $past(lv0) - 1'b1));
endmodule

bind split_fifo_ctrl sfc_chk #(.LEVELS(LEVELS)) i_sfc_chk (
  .clk_i, .rst_ni, .pop_i, .level_o, .dma_req_o, .dma_cap_o, .err_o
);

// File: tb/test_split_fifo_ctrl.sv
module test_split_fifo_ctrl;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]  chan_en_i = 2'b11, dir_i = 2'b11, push_i = '0, pop_i = '0;
  logic [1:0]  irq_i = '0, rd_flush_en_i = '0, eos_flush_en_i = '0;
  logic        cfg_load_i = 1'b0;
  logic [1:0]  cfg_split_i = '0;
  logic [3:0]  cfg_thr_i = '0;
  logic [63:0] push_data_i = '0, pop_data_o;
  logic [23:0] sect_bytes_i = '0;
  logic [9:0]  level_o;
  logic [1:0]  dma_req_o, dma_cap_o, err_o;
  int vectors = 0, miscompares = 0;

  always #2.5 clk_i = ~clk_i;

  split_fifo_ctrl i_split_fifo_ctrl (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] lvl(input int c);
    return level_o[c*5 +: 5];
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_reset(input logic [1:0] en);
    @(negedge clk_i);
    rst_ni = 1'b0; chan_en_i = en;
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  task automatic push_n(input int c, input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      push_i[c] = 1'b1;
      push_data_i[c*32 +: 32] = seed + 32'(i);
      cyc(1);
      push_i[c] = 1'b0;
    end
  endtask

  task automatic pop_n(input int c, input int n);
    for (int i = 0; i < n; i++) begin
      pop_i[c] = 1'b1;
      cyc(1);
      pop_i[c] = 1'b0;
    end
  endtask

  task automatic load_cfg(input logic [1:0] sp, input logic [3:0] th);
    cfg_split_i = sp; cfg_thr_i = th; cfg_load_i = 1'b1;
    cyc(1);
    cfg_load_i = 1'b0;
  endtask

  task automatic t_reset_state;
    check("R11 reset level", {22'd0, level_o}, 32'd0);
    check("R10 reset err", {30'd0, err_o}, 32'd0);
    check("R8 even cap", {30'd0, dma_cap_o}, 32'd3);
    check("R5 reset req", {30'd0, dma_req_o}, 32'd0);
  endtask

  task automatic t_order;
    push_n(0, 3, 32'hA0);
    check("R11 level after 3", {27'd0, lvl(0)}, 32'd3);
    for (int i = 0; i < 3; i++) begin
      check("R1 pop order", pop_data_o[31:0], 32'hA0 + 32'(i));
      pop_n(0, 1);
    end
    check("R11 level drained", {27'd0, lvl(0)}, 32'd0);
  endtask

  task automatic t_thr_d2m;
    push_n(0, 3, 32'h10);
    check("R5 below half", {31'd0, dma_req_o[0]}, 32'd0);
    push_n(0, 1, 32'h13);
    check("R4 half of 8 reached", {31'd0, dma_req_o[0]}, 32'd1);
    pop_n(0, 4);
  endtask

  task automatic t_m2d;
    dir_i[1] = 1'b0;
    cyc(1);
    check("R5 m2d empty", {31'd0, dma_req_o[1]}, 32'd1);
    push_n(1, 4, 32'h20);
    check("R5 m2d free 4", {31'd0, dma_req_o[1]}, 32'd1);
    push_n(1, 1, 32'h24);
    check("R5 m2d free 3", {31'd0, dma_req_o[1]}, 32'd0);
    check("R1 ch1 head", pop_data_o[63:32], 32'h20);
    pop_n(1, 5);
    dir_i[1] = 1'b1;
  endtask

  task automatic t_rdflush;
    push_n(0, 2, 32'h30);
    irq_i[0] = 1'b1; cyc(1); irq_i[0] = 1'b0; cyc(1);
    check("R6 irq disabled", {31'd0, dma_req_o[0]}, 32'd0);
    rd_flush_en_i[0] = 1'b1;
    irq_i[0] = 1'b1; cyc(1); irq_i[0] = 1'b0;
    check("R6 drain on irq", {31'd0, dma_req_o[0]}, 32'd1);
    pop_n(0, 1);
    check("R6 drain holds", {31'd0, dma_req_o[0]}, 32'd1);
    pop_n(0, 1);
    check("R6 drain ends", {31'd0, dma_req_o[0]}, 32'd0);
    rd_flush_en_i[0] = 1'b0;
  endtask

  task automatic t_eos;
    sect_bytes_i[11:0] = 12'd12;
    eos_flush_en_i[0] = 1'b1;
    push_n(0, 2, 32'h40);
    check("R7 before sector end", {31'd0, dma_req_o[0]}, 32'd0);
    push_n(0, 1, 32'h42);
    check("R7 sector end drain", {31'd0, dma_req_o[0]}, 32'd1);
    pop_n(0, 3);
    eos_flush_en_i[0] = 1'b0;
    check("R7 drained", {31'd0, dma_req_o[0]}, 32'd0);
  endtask

  task automatic t_cfg_defer;
    push_n(0, 1, 32'h50);
    load_cfg(2'b00, 4'b0000);
    cyc(3);
    check("R9 deferred", {30'd0, dma_cap_o}, 32'd3);
    pop_n(0, 1);
    cyc(2);
    check("R9 applied R2 split 00", {30'd0, dma_cap_o}, 32'd1);
  endtask

  task automatic t_full16;
    push_n(0, 15, 32'h100);
    check("R4 full code 15", {31'd0, dma_req_o[0]}, 32'd0);
    push_n(0, 1, 32'h10F);
    check("R4 full code 16", {31'd0, dma_req_o[0]}, 32'd1);
    check("R2 16 levels", {27'd0, lvl(0)}, 32'd16);
    push_n(0, 1, 32'h1FF);
    check("R10 overflow err", {31'd0, err_o[0]}, 32'd1);
    check("R10 overflow ignored", {27'd0, lvl(0)}, 32'd16);
    dir_i[1] = 1'b0;
    cyc(1);
    check("R3 no req unalloc", {31'd0, dma_req_o[1]}, 32'd0);
    push_n(1, 1, 32'h77);
    check("R3 push unalloc err", {31'd0, err_o[1]}, 32'd1);
    check("R3 push unalloc level", {27'd0, lvl(1)}, 32'd0);
    dir_i[1] = 1'b1;
    pop_n(0, 15);
    check("R1 last word", pop_data_o[31:0], 32'h10F);
    pop_n(0, 1);
    cyc(2);
    check("R10 sticky", {30'd0, err_o}, 32'd3);
  endtask

  task automatic t_reset_default;
    do_reset(2'b01);
    check("R8 ch0 only cap", {30'd0, dma_cap_o}, 32'd1);
    check("R10 reset clears err", {30'd0, err_o}, 32'd0);
    push_n(0, 11, 32'h200);
    check("R8 3/4 of 16 at 11", {31'd0, dma_req_o[0]}, 32'd0);
    push_n(0, 1, 32'h20B);
    check("R8 3/4 of 16 at 12", {31'd0, dma_req_o[0]}, 32'd1);
    do_reset(2'b10);
    check("R8 ch1 only cap", {30'd0, dma_cap_o}, 32'd2);
    push_n(1, 12, 32'h300);
    check("R8 ch1 3/4", {31'd0, dma_req_o[1]}, 32'd1);
    check("R2 ch1 base 0 head", pop_data_o[63:32], 32'h300);
    do_reset(2'b11);
    pop_n(1, 1);
    check("R10 underflow err", {31'd0, err_o[1]}, 32'd1);
    check("R10 underflow level", {27'd0, lvl(1)}, 32'd0);
  endtask

  task automatic t_split10;
    do_reset(2'b00);
    load_cfg(2'b10, 4'b1111);
    cyc(2);
    check("R2 split 10 cap", {30'd0, dma_cap_o}, 32'd3);
    push_n(0, 1, 32'h400);
    check("R4 quarter at 1", {31'd0, dma_req_o[0]}, 32'd0);
    push_n(0, 1, 32'h401);
    check("R4 quarter of 8 at 2", {31'd0, dma_req_o[0]}, 32'd1);
    push_n(1, 8, 32'h500);
    check("R2 ch1 holds 8", {27'd0, lvl(1)}, 32'd8);
    check("R2 ch1 no err", {31'd0, err_o[1]}, 32'd0);
    push_n(1, 1, 32'h508);
    check("R2 ch1 9th overflows", {31'd0, err_o[1]}, 32'd1);
    check("R1 ch0 separate", pop_data_o[31:0], 32'h400);
    check("R1 ch1 separate", pop_data_o[63:32], 32'h500);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset_state();
    t_order();
    t_thr_d2m();
    t_m2d();
    t_rdflush();
    t_eos();
    t_cfg_defer();
    t_full16();
    t_reset_default();
    t_split10();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule